// File: doc/BRIEF.md
# Split-Space Page Table Walker

This block turns a virtual address into a physical address for an address space split in two halves. Addresses with the top bit set belong to a system half that all processes share. Addresses with the top bit clear belong to a user half that is private to the running process. Each half has its own single-level page table, described by a base and a page-count limit. The walker fetches page table entries (PTEs) through a memory read port that allows one read at a time. It returns either a physical address or a fault.

The system table base is a physical address, so a system access needs at most one table read. The user table base is itself a system virtual address. Before the user PTE can be read, its own address must be translated through the system table, using the same lookup logic. A user access therefore makes two reads in sequence: the system PTE that maps the user table page, then the user PTE. The base and limit inputs come from registers outside this block and are held stable while a walk is in progress.

Pages are 4 KiB. A PTE is 32 bits wide: bit 31 is valid, bit 30 is resident, and bits 19:0 hold the frame number.

Top module: `split_xlate`

## Requirements
- R1: Bit 31 of `req_va` selects the region. 1 means system and uses the system table. 0 means user and uses the user table, reached through the system table.
- R2: A system access with page number `p = va[30:12]` reads exactly one PTE, at physical address `sys_base + 4*p`.
- R3: A user access reads first the system PTE at `sys_base + 4*q`, then the user PTE at `{sysframe, pteva[11:0]}`. Here `pteva = usr_base + 4*va[30:12]` and `q = pteva[30:12]`.
- R4: The walk ends with access violation and makes no memory read when a page number is not below its table's limit (`sys_len` or `usr_len`, counted in entries).
- R5: A fetched PTE with bit 31 clear ends the walk with access violation.
- R6: A fetched PTE with bit 31 set and bit 30 clear ends the walk with page fault.
- R7: A fault sets `rsp_err` to 1. `rsp_code[0]` is 0 for access violation and 1 for page fault. `rsp_code[1]` is 0 when the fault came from the system-table stage and 1 when it came from the user-table stage. A success returns `rsp_err` = 0 and `rsp_code` = 00.
- R8: On success, `rsp_pa = {frame, va[11:0]}`, where `frame` is bits 19:0 of the last PTE read.
- R9: `req_ready` is high only while idle. A `req_valid` seen while busy is ignored. Each accepted request gives exactly one single-cycle `rsp_valid` pulse.
- R10: A user table address (`pteva`) whose bit 31 is 0 ends the walk with a system-stage access violation and makes no read.
- R11: `mem_req` and `mem_addr` stay stable from when a read is raised until the cycle in which `mem_rvalid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | High when idle; a request is taken when both are high |
| req_va | input | 32 | Virtual address to translate |
| sys_base | input | 32 | Physical base of the system page table |
| sys_len | input | 20 | System table length in entries |
| usr_base | input | 32 | System-virtual base of the user page table |
| usr_len | input | 20 | User table length in entries |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | 1 when the response is a fault |
| rsp_code | output | 2 | Fault code: bit 1 stage, bit 0 kind |
| rsp_pa | output | 32 | Physical address on success |
| mem_req | output | 1 | PTE read request, held until data returns |
| mem_addr | output | 32 | Physical address of the PTE read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | PTE read data |

## Verification
On every cycle, the assertions check the handshake rules. The memory request stays stable until its data returns. Only one response pulse is given per accepted request. The block is busy after it accepts a request and never reads while idle. A success never carries a fault code. Only the bench scenarios can show the table arithmetic, the order of the nested user read, the limit boundaries and the fault classification for each stage, because those outcomes depend on the table contents and on the configuration.

// File: rtl/split_xlate_pkg.sv
package split_xlate_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int FRAME_W   = 20;
    localparam int PTE_W     = 32;
    localparam int PTE_VBIT  = 31;
    localparam int PTE_RBIT  = 30;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_SYSRD  = 2'd2,
        ST_USRRD  = 2'd3
    } walk_state_e;

    // rsp_code: bit 1 = stage (0 system, 1 user), bit 0 = kind (0 violation, 1 page fault)
    localparam logic [1:0] FC_SYS_AV = 2'b00;
    localparam logic [1:0] FC_SYS_PF = 2'b01;
    localparam logic [1:0] FC_USR_AV = 2'b10;
    localparam logic [1:0] FC_USR_PF = 2'b11;
endpackage

// File: rtl/xl_table_index.sv
module xl_table_index #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ADDR_W    = 32,
    localparam int VPN_W    = VA_W - 1 - PAGE_BITS,
    localparam int LEN_W    = VPN_W + 1
) (
    input  logic [VA_W-1:0]   va,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    output logic              beyond,
    output logic [ADDR_W-1:0] entry_addr
);
    logic [VPN_W-1:0] vpn;

    always_comb begin
        vpn        = va[VA_W-2:PAGE_BITS];
        beyond     = ({1'b0, vpn} >= len);
        entry_addr = base + ADDR_W'({vpn, 2'b00});
    end
endmodule

// File: rtl/xl_pte_check.sv
module xl_pte_check
    import split_xlate_pkg::*;
(
    input  logic [PTE_W-1:0]   pte,
    output logic               bad_entry,
    output logic               not_present,
    output logic [FRAME_W-1:0] frame
);
    always_comb begin
        bad_entry   = !pte[PTE_VBIT];
        not_present = pte[PTE_VBIT] && !pte[PTE_RBIT];
        frame       = pte[FRAME_W-1:0];
    end
endmodule

// File: rtl/split_xlate.sv
module split_xlate
    import split_xlate_pkg::*;
#(
    localparam int PA_W  = FRAME_W + PAGE_BITS,
    localparam int VPN_W = VA_W - 1 - PAGE_BITS,
    localparam int LEN_W = VPN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic [PA_W-1:0]  sys_base,
    input  logic [LEN_W-1:0] sys_len,
    input  logic [VA_W-1:0]  usr_base,
    input  logic [LEN_W-1:0] usr_len,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [1:0]       rsp_code,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    typedef struct packed {
        walk_state_e      state;
        logic [VA_W-1:0]  va;
        logic             rsp_valid;
        logic             rsp_err;
        logic [1:0]       rsp_code;
        logic [PA_W-1:0]  rsp_pa;
        logic             mem_req;
        logic [PA_W-1:0]  mem_addr;
    } walk_t;

    walk_t walk_d, walk_q;

    logic              in_user;
    logic              usr_beyond;
    logic [VA_W-1:0]   pte_va;
    logic [VA_W-1:0]   sys_lookup_va;
    logic              sys_beyond;
    logic [PA_W-1:0]   sys_entry_pa;
    logic              pte_bad;
    logic              pte_absent;
    logic [FRAME_W-1:0] pte_frame;

    // user table: base is a system virtual address
    xl_table_index #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .ADDR_W(VA_W)) u_usr_idx (
        .va(walk_q.va), .base(usr_base), .len(usr_len),
        .beyond(usr_beyond), .entry_addr(pte_va)
    );

    // one system lookup path serves both direct and nested accesses
    assign in_user       = !walk_q.va[VA_W-1];
    assign sys_lookup_va = in_user ? pte_va : walk_q.va;

    xl_table_index #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .ADDR_W(PA_W)) u_sys_idx (
        .va(sys_lookup_va), .base(sys_base), .len(sys_len),
        .beyond(sys_beyond), .entry_addr(sys_entry_pa)
    );

    xl_pte_check u_pte (
        .pte(mem_rdata), .bad_entry(pte_bad), .not_present(pte_absent), .frame(pte_frame)
    );

    always_comb begin
        walk_d           = walk_q;
        walk_d.rsp_valid = 1'b0;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.va    = req_va;
                    walk_d.state = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (in_user && usr_beyond) begin
                    walk_d.rsp_valid = 1'b1;
                    walk_d.rsp_err   = 1'b1;
                    walk_d.rsp_code  = FC_USR_AV;
                    walk_d.state     = ST_IDLE;
                end else if (!sys_lookup_va[VA_W-1] || sys_beyond) begin
                    walk_d.rsp_valid = 1'b1;
                    walk_d.rsp_err   = 1'b1;
                    walk_d.rsp_code  = FC_SYS_AV;
                    walk_d.state     = ST_IDLE;
                end else begin
                    walk_d.mem_req  = 1'b1;
                    walk_d.mem_addr = sys_entry_pa;
                    walk_d.state    = ST_SYSRD;
                end
            end
            ST_SYSRD: begin
                if (mem_rvalid) begin
                    walk_d.mem_req = 1'b0;
                    if (pte_bad || pte_absent) begin
                        walk_d.rsp_valid = 1'b1;
                        walk_d.rsp_err   = 1'b1;
                        walk_d.rsp_code  = pte_bad ? FC_SYS_AV : FC_SYS_PF;
                        walk_d.state     = ST_IDLE;
                    end else if (in_user) begin
                        walk_d.mem_req  = 1'b1;
                        walk_d.mem_addr = {pte_frame, pte_va[PAGE_BITS-1:0]};
                        walk_d.state    = ST_USRRD;
                    end else begin
                        walk_d.rsp_valid = 1'b1;
                        walk_d.rsp_err   = 1'b0;
                        walk_d.rsp_code  = 2'b00;
                        walk_d.rsp_pa    = {pte_frame, walk_q.va[PAGE_BITS-1:0]};
                        walk_d.state     = ST_IDLE;
                    end
                end
            end
            ST_USRRD: begin
                if (mem_rvalid) begin
                    walk_d.mem_req   = 1'b0;
                    walk_d.rsp_valid = 1'b1;
                    walk_d.state     = ST_IDLE;
                    if (pte_bad || pte_absent) begin
                        walk_d.rsp_err  = 1'b1;
                        walk_d.rsp_code = pte_bad ? FC_USR_AV : FC_USR_PF;
                    end else begin
                        walk_d.rsp_err  = 1'b0;
                        walk_d.rsp_code = 2'b00;
                        walk_d.rsp_pa   = {pte_frame, walk_q.va[PAGE_BITS-1:0]};
                    end
                end
            end
            default: walk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{state: ST_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready = (walk_q.state == ST_IDLE);
    assign rsp_valid = walk_q.rsp_valid;
    assign rsp_err   = walk_q.rsp_err;
    assign rsp_code  = walk_q.rsp_code;
    assign rsp_pa    = walk_q.rsp_pa;
    assign mem_req   = walk_q.mem_req;
    assign mem_addr  = walk_q.mem_addr;

    // R11: an outstanding read keeps its address until data returns
    p_read_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R9: a response is a single-cycle pulse
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: an accepted request makes the block busy
    p_busy_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: no table read while idle
    p_no_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R7: a success carries no fault code
    p_ok_code_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> (rsp_code == 2'b00));
endmodule

// File: tb/tb_split_xlate.sv
`timescale 1ns/1ps
module tb_split_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] sys_base = 32'h0001_0000;
    logic [19:0] sys_len = 20'd16;
    logic [31:0] usr_base = 32'h8000_2000;
    logic [19:0] usr_len = 20'd8;
    logic        rsp_valid, rsp_err;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_pa;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    logic [31:0] addr0, addr1;

    always #2 clk = ~clk;

    split_xlate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .sys_base(sys_base), .sys_len(sys_len),
        .usr_base(usr_base), .usr_len(usr_len), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_code(rsp_code), .rsp_pa(rsp_pa),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] table_word(input logic [31:0] a);
        case (a)
            32'h0001_0008: return 32'hC000_0050; // system page 2 holds the user table
            32'h0001_000C: return 32'hC001_2345;
            32'h0001_0010: return 32'h0000_0000;
            32'h0001_0014: return 32'h8000_0077;
            32'h0005_0004: return 32'hC000_ABCD;
            32'h0005_0008: return 32'h0000_0000;
            32'h0005_000C: return 32'h8000_0011;
            default:       return 32'h0000_0000;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: two-cycle latency, checks that an open read keeps its address
    initial begin
        logic busy = 1'b0;
        logic [31:0] cap = '0;
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                busy = 1'b0;
            end else if (mem_req) begin
                if (!busy) begin
                    busy = 1'b1; cnt = 0; cap = mem_addr;
                    if (reads == 0) addr0 = mem_addr; else addr1 = mem_addr;
                    reads++;
                end else if (mem_addr !== cap) begin
                    checks++; fails++;
                    $display("FAIL R11: actual %h expected %h", mem_addr, cap);
                end
                cnt++;
                if (cnt == 2) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = table_word(cap);
                end
            end
        end
    end

    // send one request; noise drives req_valid while busy to show it is ignored
    task automatic walk(input logic [31:0] va, input bit noise,
                        output logic e, output logic [1:0] c, output logic [31:0] pa,
                        output int nrsp);
        int t;
        reads = 0; addr0 = '0; addr1 = '0; nrsp = 0;
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = noise; req_va = 32'h8000_3000;
        if (noise) check("R9 ready low while busy", {31'd0, req_ready}, 32'd0);
        t = 0;
        while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
        req_valid = 1'b0;
        if (t >= 100) begin
            checks++; fails++;
            $display("FAIL watchdog: actual no response expected response");
        end
        e = rsp_err; c = rsp_code; pa = rsp_pa; nrsp = rsp_valid ? 1 : 0;
        repeat (6) begin @(negedge clk); if (rsp_valid) nrsp++; end
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        err;
        logic [1:0]  code;
        logic [31:0] pa;
        logic [1:0]  nrd;
        logic [31:0] a0;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'h8000_3ABC, 1'b0, 2'b00, 32'h1234_5ABC, 2'd1, 32'h0001_000C}, // R1 R2 R8
        '{32'h8000_4000, 1'b1, 2'b00, 32'h0,        2'd1, 32'h0001_0010}, // R5
        '{32'h8000_5FFF, 1'b1, 2'b01, 32'h0,        2'd1, 32'h0001_0014}, // R6
        '{32'h8001_0000, 1'b1, 2'b00, 32'h0,        2'd0, 32'h0},         // R4
        '{32'h8000_F000, 1'b1, 2'b00, 32'h0,        2'd1, 32'h0001_003C}, // R4 last entry
        '{32'h0000_1123, 1'b0, 2'b00, 32'h0ABC_D123, 2'd2, 32'h0001_0008}, // R3 R8
        '{32'h0000_2000, 1'b1, 2'b10, 32'h0,        2'd2, 32'h0001_0008}, // R5 R7
        '{32'h0000_3456, 1'b1, 2'b11, 32'h0,        2'd2, 32'h0001_0008}, // R6 R7
        '{32'h0000_8000, 1'b1, 2'b10, 32'h0,        2'd0, 32'h0}          // R4 R7
    };

    initial begin
        logic e; logic [1:0] c; logic [31:0] pa; int n;
        repeat (3) @(negedge clk);
        check("R9 reset ready", {31'd0, req_ready}, 32'd1);
        check("R9 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R11 reset mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            walk(VECS[i].va, 1'b0, e, c, pa, n);
            check("R7 err", {31'd0, e}, {31'd0, VECS[i].err});
            check("R7 code", {30'd0, c}, {30'd0, VECS[i].code});
            if (!VECS[i].err) check("R8 pa", pa, VECS[i].pa);
            check("R4 read count", reads, {30'd0, VECS[i].nrd});
            if (VECS[i].nrd != 0) check("R2 first read addr", addr0, VECS[i].a0);
            check("R9 one response", n, 1);
        end

        // R3: nested read order for a user access
        walk(32'h0000_1123, 1'b0, e, c, pa, n);
        check("R3 system read", addr0, 32'h0001_0008);
        check("R3 user read", addr1, 32'h0005_0004);

        // R9: request presented while busy is ignored
        walk(32'h0000_1123, 1'b1, e, c, pa, n);
        check("R9 result kept", pa, 32'h0ABC_D123);
        check("R9 single response", n, 1);
        check("R9 read count", reads, 2);

        // R10: user table base in the user half
        usr_base = 32'h0000_4000;
        walk(32'h0000_1000, 1'b0, e, c, pa, n);
        check("R10 err", {31'd0, e}, 32'd1);
        check("R10 code", {30'd0, c}, {30'd0, 2'b00});
        check("R10 no read", reads, 0);

        // R1 R5: user table on an invalid system page faults at the system stage
        usr_base = 32'h8000_4000;
        walk(32'h0000_1000, 1'b0, e, c, pa, n);
        check("R5 nested err", {31'd0, e}, 32'd1);
        check("R7 nested stage", {30'd0, c}, {30'd0, 2'b00});
        check("R1 nested read addr", addr0, 32'h0001_0010);

        // R4: shrink the system limit so page 3 is outside
        sys_len = 20'd3; usr_base = 32'h8000_2000;
        walk(32'h8000_3ABC, 1'b0, e, c, pa, n);
        check("R4 limit err", {31'd0, e}, 32'd1);
        check("R4 limit no read", reads, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule